// File: doc/BRIEF.md
# Circular DMA Level-Watermark Tracker

This block follows the consumer position inside a circular buffer of words held in memory. Software programs a base byte address, a buffer length in words and up to four watermark byte addresses, each with its own enable. Each time the consumer reports that it has taken N words, the block moves a word position forward modulo the buffer length. It also reports which enabled watermarks fall inside the bytes that this step consumed.

The bytes consumed by one step run from the current position up to the position N words later. When that span runs past the end of the buffer, it is split into a tail span up to the end and a head span that starts again at offset zero. Each watermark whose address lies in either span produces a one-cycle set pulse. The pulse also sets a sticky flag, and the flags drive a shared interrupt line. The block presents the byte address of the current read position, so that the memory fetcher, which is not part of this block, knows where to read next.

Advance requests arrive as a one-cycle strobe. The position update, the watermark pulses and the reject pulse all show up one clock edge after the strobe. The four watermark comparisons run side by side.

Top module: `dma_ring_watermark`

## Requirements
- R1: After reset, the position is 0 and the watermark pulses, sticky flags, interrupt and reject pulse are all 0.
- R2: An accepted advance of N words (1 <= N <= length) sets the position to (position + N) mod length on the edge after the strobe. N equal to the length leaves the position unchanged.
- R3: An advance is rejected if N is greater than the length or if the length is 0. A rejected advance raises the reject pulse for one cycle after the strobe, leaves the position unchanged and produces no watermark pulse.
- R4: A watermark whose enable bit (bit i of the enable vector for channel i) is 0 never pulses.
- R5: A watermark address below the base address never pulses.
- R6: When an advance does not pass the buffer end, channel i pulses exactly when (its address minus base) lies in [position*4, (position+N)*4). Words are 4 bytes.
- R7: When position + N is greater than the length, channel i pulses if its offset lies in [position*4, length*4) or in [0, (position+N-length)*4).
- R8: A pulse on channel i sets sticky flag i. A clear bit removes the flag on the next edge unless a pulse sets it on that same edge. The interrupt output is the OR of the flags.
- R9: The read address output is base + position*4, formed combinationally from the current inputs and the stored position.
- R10: If the programmed length is not greater than the stored position, the position is treated as 0: the read address is the base at once, and the stored position becomes 0 on the next edge.
- R11: With no strobe, or with an accepted advance of N = 0, no watermark pulses and the position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Buffer base byte address |
| size_words | input | 16 | Buffer length in words |
| lvl_addr | input | 128 | Four watermark byte addresses, channel i in bits 32*i+31:32*i |
| lvl_en | input | 4 | Watermark enables, bit i for channel i |
| lvl_clr | input | 4 | Sticky flag clear, bit i for channel i |
| adv_valid | input | 1 | One-cycle advance strobe |
| adv_words | input | 16 | Words consumed by this advance |
| count | output | 24 | Stored word position |
| rd_addr | output | 32 | Byte address of the current read position |
| lvl_pulse | output | 4 | One-cycle watermark set pulses |
| lvl_flags | output | 4 | Sticky watermark flags |
| irq | output | 1 | OR of the sticky flags |
| adv_err | output | 1 | One-cycle reject pulse |

## Verification
Some properties are checked by assertions on every cycle. Rejects never move the position and never pulse. Disabled channels stay silent. Nothing pulses without a strobe. The position always stays below the length seen on the previous cycle. Flags stay set until cleared, and every pulse lands in the flags and the interrupt. Other behaviour can only be shown by the bench's scenarios against a word-by-word reference model: whether a given watermark is hit inside the exact byte range, how a wrapping advance is split, how a mid-word watermark or one below the base is handled, and how the position collapses when the length shrinks.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  // Byte span test: lo <= off < hi
  function automatic logic in_span(input logic [31:0] off,
                                   input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (off >= lo) && (off < hi);
  endfunction

  // Word count to byte count
  function automatic logic [31:0] w2b(input logic [31:0] words,
                                      input logic [31:0] word_bytes);
    return words * word_bytes;
  endfunction
endpackage

// File: rtl/dmaw_ring_step.sv
module dmaw_ring_step #(
  parameter int CNT_W  = 24,
  parameter int SIZE_W = 16,
  localparam int SPAN_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [SIZE_W-1:0] size_w,
  input  logic [SIZE_W-1:0] adv_n,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [SPAN_W-1:0] tail_end,
  output logic [SPAN_W-1:0] head_end,
  output logic              wrap,
  output logic              reject,
  output logic [CNT_W-1:0]  next_cnt
);
  logic [SPAN_W-1:0] size_x;
  logic [SPAN_W-1:0] sum;

  assign size_x   = SPAN_W'(size_w);
  assign cur_cnt  = (SPAN_W'(cnt_q) >= size_x) ? '0 : cnt_q;
  assign sum      = SPAN_W'(cur_cnt) + SPAN_W'(adv_n);
  assign reject   = (size_w == '0) || (adv_n > size_w);
  assign wrap     = sum > size_x;
  assign tail_end = wrap ? size_x : sum;
  assign head_end = wrap ? (sum - size_x) : '0;
  assign next_cnt = CNT_W'((sum >= size_x) ? (sum - size_x) : sum);
endmodule

// File: rtl/dmaw_lvl_cmp.sv
module dmaw_lvl_cmp #(
  parameter int ADDR_W     = 32,
  parameter int SPAN_W     = 25,
  parameter int WORD_BYTES = 4
) (
  input  logic              active,
  input  logic              en,
  input  logic [ADDR_W-1:0] lvl,
  input  logic [ADDR_W-1:0] base,
  input  logic [SPAN_W-1:0] lo_w,
  input  logic [SPAN_W-1:0] tail_w,
  input  logic              wrap,
  input  logic [SPAN_W-1:0] head_w,
  output logic              hit
);
  import dmaw_pkg::*;
  localparam logic [31:0] WB = 32'(WORD_BYTES);

  logic        below;
  logic [31:0] off;
  logic        hit_tail;
  logic        hit_head;

  assign below    = lvl < base;
  assign off      = 32'(lvl - base);
  assign hit_tail = in_span(off, w2b(32'(lo_w), WB), w2b(32'(tail_w), WB));
  assign hit_head = wrap && in_span(off, 32'd0, w2b(32'(head_w), WB));
  assign hit      = active && en && !below && (hit_tail || hit_head);
endmodule

// File: rtl/dma_ring_watermark.sv
module dma_ring_watermark #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int SIZE_W     = 16,
  parameter int NUM_LVL    = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [SIZE_W-1:0]         size_words,
  input  logic [NUM_LVL*ADDR_W-1:0] lvl_addr,
  input  logic [NUM_LVL-1:0]        lvl_en,
  input  logic [NUM_LVL-1:0]        lvl_clr,
  input  logic                      adv_valid,
  input  logic [SIZE_W-1:0]         adv_words,
  output logic [CNT_W-1:0]          count,
  output logic [ADDR_W-1:0]         rd_addr,
  output logic [NUM_LVL-1:0]        lvl_pulse,
  output logic [NUM_LVL-1:0]        lvl_flags,
  output logic                      irq,
  output logic                      adv_err
);
  localparam int SPAN_W = CNT_W + 1;
  localparam logic [ADDR_W-1:0] WB = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cur_cnt;
  logic [CNT_W-1:0]   next_cnt;
  logic [SPAN_W-1:0]  tail_end;
  logic [SPAN_W-1:0]  head_end;
  logic               wrap_evt;
  logic               reject;
  logic               adv_ok;
  logic               adv_rej;
  logic               adv_live;
  logic [NUM_LVL-1:0] hit_vec;
  logic [NUM_LVL-1:0] pulse_q;
  logic [NUM_LVL-1:0] flags_q;
  logic               err_q;

  dmaw_ring_step #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_step (
    .cnt_q    (cnt_q),
    .size_w   (size_words),
    .adv_n    (adv_words),
    .cur_cnt  (cur_cnt),
    .tail_end (tail_end),
    .head_end (head_end),
    .wrap     (wrap_evt),
    .reject   (reject),
    .next_cnt (next_cnt)
  );

  assign adv_ok   = adv_valid && !reject;
  assign adv_rej  = adv_valid && reject;
  assign adv_live = adv_ok && (adv_words != '0);

  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    dmaw_lvl_cmp #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .WORD_BYTES(WORD_BYTES)) u_cmp (
      .active (adv_live),
      .en     (lvl_en[i]),
      .lvl    (lvl_addr[i*ADDR_W +: ADDR_W]),
      .base   (base_addr),
      .lo_w   (SPAN_W'(cur_cnt)),
      .tail_w (tail_end),
      .wrap   (wrap_evt),
      .head_w (head_end),
      .hit    (hit_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= '0;
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= adv_ok ? next_cnt : cur_cnt;
      pulse_q <= hit_vec;
      flags_q <= (flags_q & ~lvl_clr) | hit_vec;
      err_q   <= adv_rej;
    end
  end

  assign count     = cnt_q;
  assign rd_addr   = base_addr + ADDR_W'(cur_cnt) * WB;
  assign lvl_pulse = pulse_q;
  assign lvl_flags = flags_q;
  assign irq       = |flags_q;
  assign adv_err   = err_q;
endmodule

// File: rtl/dmaw_chk.sv
module dmaw_chk #(
  parameter int CNT_W   = 24,
  parameter int SIZE_W  = 16,
  parameter int NUM_LVL = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               adv_valid,
  input logic               adv_rej,
  input logic [SIZE_W-1:0]  size_words,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_LVL-1:0] lvl_en,
  input logic [NUM_LVL-1:0] lvl_clr,
  input logic [NUM_LVL-1:0] lvl_pulse,
  input logic [NUM_LVL-1:0] lvl_flags,
  input logic               irq,
  input logic               adv_err
);
  // R3
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_rej |=> (adv_err && (lvl_pulse == '0)));

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_rej && (count < CNT_W'(size_words))) |=> $stable(count));

  // R4
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid |=> ((lvl_pulse & ~$past(lvl_en)) == '0));

  // R11
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> ((lvl_pulse == '0) && !adv_err));

  // R2
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(size_words) != '0) |-> (count < CNT_W'($past(size_words))));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lvl_flags) & ~$past(lvl_clr) & ~lvl_flags) == '0));

  // R8
  pulse_to_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_pulse != '0) |-> (irq && ((lvl_pulse & ~lvl_flags) == '0)));
endmodule

bind dma_ring_watermark dmaw_chk #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .NUM_LVL(NUM_LVL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv_valid  (adv_valid),
  .adv_rej    (adv_rej),
  .size_words (size_words),
  .count      (count),
  .lvl_en     (lvl_en),
  .lvl_clr    (lvl_clr),
  .lvl_pulse  (lvl_pulse),
  .lvl_flags  (lvl_flags),
  .irq        (irq),
  .adv_err    (adv_err)
);

// File: tb/dma_ring_watermark_tb.sv
module dma_ring_watermark_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  base_addr = BASE;
  logic [15:0]  size_words = 16'd16;
  logic [127:0] lvl_addr;
  logic [3:0]   lvl_en = 4'b1111;
  logic [3:0]   lvl_clr = '0;
  logic         adv_valid = 1'b0;
  logic [15:0]  adv_words = '0;
  logic [23:0]  count;
  logic [31:0]  rd_addr;
  logic [3:0]   lvl_pulse;
  logic [3:0]   lvl_flags;
  logic         irq;
  logic         adv_err;

  dma_ring_watermark u_dut (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .size_words(size_words),
    .lvl_addr(lvl_addr), .lvl_en(lvl_en), .lvl_clr(lvl_clr),
    .adv_valid(adv_valid), .adv_words(adv_words), .count(count),
    .rd_addr(rd_addr), .lvl_pulse(lvl_pulse), .lvl_flags(lvl_flags),
    .irq(irq), .adv_err(adv_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [23:0] cnt;
    logic [3:0]  pulse;
    logic [3:0]  flags;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int unsigned m_cnt = 0;
  logic [3:0]  m_flags = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Reference: walk each consumed word and test every byte it covers
  function automatic logic [3:0] ref_hits(input int unsigned c, input int unsigned n,
                                          input int unsigned sz);
    logic [3:0] h = '0;
    for (int ch = 0; ch < 4; ch++) begin
      longint la = longint'(lvl_addr[ch*32 +: 32]);
      longint off = la - longint'(base_addr);
      if (lvl_en[ch] && off >= 0) begin
        for (int k = 0; k < int'(n); k++) begin
          longint w = longint'((c + k) % sz);
          if (off >= w * 4 && off < w * 4 + 4) h[ch] = 1'b1;
        end
      end
    end
    return h;
  endfunction

  task automatic advance(input int unsigned n, input string tag);
    exp_t e;
    int unsigned c;
    int unsigned sz;
    @(negedge clk);
    sz = size_words;
    c = (m_cnt >= sz) ? 0 : m_cnt;
    e.tag = tag;
    e.err = (sz == 0) || (n > sz);
    if (e.err) begin
      e.pulse = '0;
      m_cnt = c;
    end else begin
      e.pulse = ref_hits(c, n, sz);
      m_cnt = (c + n) % sz;
    end
    m_flags = m_flags | e.pulse;
    e.cnt = 24'(m_cnt);
    e.flags = m_flags;
    sb.push_back(e);
    adv_words = 16'(n);
    adv_valid = 1'b1;
    @(negedge clk);
    adv_valid = 1'b0;
    adv_words = '0;
  endtask

  task automatic clear_flags(input logic [3:0] m, input string tag);
    @(negedge clk);
    lvl_clr = m;
    m_flags = m_flags & ~m;
    @(negedge clk);
    lvl_clr = '0;
    check(lvl_flags == m_flags, tag, "flags after clear", lvl_flags, m_flags);
    check(irq == (|m_flags), tag, "irq after clear", irq, |m_flags);
  endtask

  // Monitor: pop one expected item per strobe, sample after the edge
  always @(posedge clk) begin
    if (rst_n && adv_valid) begin
      exp_t e;
      #1;
      if (sb.size() == 0) begin
        check(1'b0, "R2", "scoreboard empty", 0, 1);
      end else begin
        e = sb.pop_front();
        check(count == e.cnt, e.tag, "count", count, e.cnt);
        check(lvl_pulse == e.pulse, e.tag, "pulse", lvl_pulse, e.pulse);
        check(adv_err == e.err, e.tag, "reject", adv_err, e.err);
        check(lvl_flags == e.flags, e.tag, "flags", lvl_flags, e.flags);
        check(irq == (|e.flags), e.tag, "irq", irq, |e.flags);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    lvl_addr[0*32 +: 32] = BASE + 32'h08;   // word 2
    lvl_addr[1*32 +: 32] = BASE + 32'h21;   // inside word 8
    lvl_addr[2*32 +: 32] = BASE + 32'h3C;   // word 15
    lvl_addr[3*32 +: 32] = BASE - 32'h04;   // below base
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(count == 0, "R1", "count", count, 0);
    check(lvl_pulse == 0 && lvl_flags == 0, "R1", "pulse/flags", {lvl_pulse, lvl_flags}, 0);
    check(!irq && !adv_err, "R1", "irq/err", {irq, adv_err}, 0);
    check(rd_addr == BASE, "R9", "rd_addr at reset", rd_addr, BASE);

    advance(3, "R6");                       // words 0..2 -> ch0
    check(rd_addr == BASE + 32'd12, "R9", "rd_addr", rd_addr, BASE + 32'd12);
    advance(6, "R6");                       // words 3..8 -> ch1 mid-word
    clear_flags(4'b0011, "R8");
    advance(10, "R7");                      // 9..15 then 0..2 -> ch2, ch0
    advance(17, "R3");                      // longer than buffer
    advance(0, "R11");
    lvl_en = 4'b1101;
    advance(8, "R4");                       // covers word 8 but ch1 off
    advance(16, "R2");                      // full lap -> ch0, ch2
    check(rd_addr == BASE + 32'd44, "R9", "rd_addr after lap", rd_addr, BASE + 32'd44);
    lvl_en = 4'b1111;
    clear_flags(4'b1111, "R8");

    // R10 shrink the buffer below the stored position
    @(negedge clk);
    size_words = 16'd8;
    #1;
    check(rd_addr == BASE, "R10", "rd_addr after shrink", rd_addr, BASE);
    @(negedge clk);
    m_cnt = 0;
    check(count == 0, "R10", "count after shrink", count, 0);
    advance(5, "R10");                      // words 0..4 -> ch0 only
    advance(8, "R5");                       // full lap, ch3 below base stays quiet

    @(negedge clk);
    size_words = 16'd0;
    advance(0, "R3");                       // zero length rejects
    size_words = 16'd16;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule